// File: doc/BRIEF.md
# Feedback-Directed Prefetch Throttle

This block sets how aggressive a hardware prefetcher is, based on how well recent prefetches have worked. It counts five kinds of one-cycle event pulses: prefetch issued, prefetch used, used prefetch that arrived late, demand miss, and demand miss caused by prefetch pollution. An interval closes on the pulse that brings the issued-prefetch count to `INTERVAL`. At that point the block classifies the interval by accuracy, lateness and pollution, and moves an aggressiveness level one step up, one step down, or leaves it where it is.

There are five levels. Each level maps to a prefetch distance and a prefetch degree, and the prefetcher reads both from registered outputs. All ratio tests use shifts, adds and cross-multiplication, so the block needs no divider. Every counter clears when an interval closes.

Top module: `fdp_throttle`

## Requirements
- R1: While `rst` is high, and after it is released, the outputs are level 2, distance 16 and degree 2.
- R2: The level sets the outputs as follows: level 0 gives (4,1), level 1 gives (8,1), level 2 gives (16,2), level 3 gives (32,4) and level 4 gives (64,4), written as (distance, degree).
- R3: An interval closes in the cycle that carries the `INTERVAL`-th `ev_sent` pulse. Its counts include the pulses of that same cycle. The new outputs appear after the second rising edge that follows that cycle. All counts then start again from zero.
- R4: Accuracy compares used (U) with sent (S). It is high when 4U >= 3S, low when 5U < 2S, and medium otherwise.
- R5: An interval is late when 8 times the late count exceeds U. It is polluting when 8 times the pollution-miss count exceeds the demand-miss count.
- R6: With high accuracy, a late interval raises the level. A polluting interval that is not late lowers it. Any other high-accuracy interval leaves it unchanged.
- R7: With medium accuracy, a polluting interval lowers the level. A late interval that is not polluting raises it. Any other medium-accuracy interval leaves it unchanged.
- R8: With low accuracy, an interval that is neither late nor polluting leaves the level unchanged. Every other low-accuracy interval lowers it.
- R9: The level saturates: it never goes above 4 or below 0.
- R10: The level changes only when an interval closes, and then by at most one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_sent | input | 1 | Pulse: a prefetch was issued |
| ev_used | input | 1 | Pulse: a demand access hit a prefetched line |
| ev_late | input | 1 | Pulse: a used prefetch was still in flight |
| ev_demand_miss | input | 1 | Pulse: a demand miss |
| ev_poll_miss | input | 1 | Pulse: a demand miss caused by prefetch pollution |
| level | output | 3 | Current aggressiveness level, 0 to 4 |
| pf_distance | output | 7 | Prefetch distance, in lines |
| pf_degree | output | 3 | Prefetch degree, in requests per trigger |

## Verification
Directed intervals cover each cell of the three-way decision table, so a swapped priority between lateness and pollution gives a different step. Other directed intervals sit exactly on the accuracy and lateness boundaries to separate `>=` from `>`. Runs of repeated up steps and repeated down steps drive the level into both saturation ends. Random intervals with mixed event counts, checked against a bench model of the table, test the counter clearing and the classification together. They include an interval with no used prefetches that follows one with many, which exposes any count carried over between intervals.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    ACC_LOW  = 2'd0,
    ACC_MED  = 2'd1,
    ACC_HIGH = 2'd2
  } acc_e;

  localparam int NUM_EV = 5;
  localparam int EV_SENT = 0;
  localparam int EV_USED = 1;
  localparam int EV_LATE = 2;
  localparam int EV_DMND = 3;
  localparam int EV_POLL = 4;
endpackage

// File: rtl/fdp_sat_counter.sv
module fdp_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    cnt_nxt = cnt;
    if (inc && (cnt != {W{1'b1}})) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt_nxt;
  end
endmodule

// File: rtl/fdp_classifier.sv
module fdp_classifier
  import fdp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] n_sent,
  input  logic [W-1:0] n_used,
  input  logic [W-1:0] n_late,
  input  logic [W-1:0] n_dmnd,
  input  logic [W-1:0] n_poll,
  output step_e        step
);
  localparam int PW = W + 4;

  logic [PW-1:0] s_w, u_w, l_w, d_w, p_w;
  logic [PW-1:0] u_x4, s_x3, u_x5, s_x2, l_x8, p_x8;
  acc_e          acc;
  logic          is_late, is_poll;

  always_comb begin
    s_w  = {4'b0, n_sent};
    u_w  = {4'b0, n_used};
    l_w  = {4'b0, n_late};
    d_w  = {4'b0, n_dmnd};
    p_w  = {4'b0, n_poll};
    u_x4 = u_w << 2;
    s_x3 = (s_w << 1) + s_w;
    u_x5 = (u_w << 2) + u_w;
    s_x2 = s_w << 1;
    l_x8 = l_w << 3;
    p_x8 = p_w << 3;

    if (u_x4 >= s_x3)     acc = ACC_HIGH;
    else if (u_x5 < s_x2) acc = ACC_LOW;
    else                  acc = ACC_MED;

    is_late = l_x8 > u_w;
    is_poll = p_x8 > d_w;

    step = STEP_HOLD;
    if (s_w != '0) begin
      unique case (acc)
        ACC_HIGH: begin
          if (is_late)      step = STEP_UP;
          else if (is_poll) step = STEP_DOWN;
        end
        ACC_MED: begin
          if (is_poll)      step = STEP_DOWN;
          else if (is_late) step = STEP_UP;
        end
        default: begin
          if (is_late || is_poll) step = STEP_DOWN;
        end
      endcase
    end
  end
endmodule

// File: rtl/fdp_level_ctrl.sv
module fdp_level_ctrl
  import fdp_pkg::*;
#(
  parameter int LEVELS      = 5,
  parameter int RESET_LEVEL = 2,
  parameter int BASE_DIST   = 4,
  parameter int DEG_CAP     = 4,
  parameter int LW          = 3,
  parameter int DW          = 7,
  parameter int GW          = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_vld,
  input  step_e         step,
  output logic [LW-1:0] level,
  output logic [DW-1:0] pf_distance,
  output logic [GW-1:0] pf_degree
);
  localparam logic [LW-1:0] TOP_LVL = LW'(LEVELS - 1);
  localparam logic [LW-1:0] RST_LVL = LW'(RESET_LEVEL);

  function automatic logic [DW-1:0] dist_of(input logic [LW-1:0] lv);
    return DW'(BASE_DIST << lv);
  endfunction

  function automatic logic [GW-1:0] deg_of(input logic [LW-1:0] lv);
    int v;
    if (lv == '0) v = 1;
    else          v = 1 << (lv - 1'b1);
    if (v > DEG_CAP) v = DEG_CAP;
    return GW'(v);
  endfunction

  logic [LW-1:0] lvl_nxt;

  always_comb begin
    lvl_nxt = level;
    if (dec_vld) begin
      if (step == STEP_UP && level != TOP_LVL)   lvl_nxt = level + 1'b1;
      if (step == STEP_DOWN && level != '0)      lvl_nxt = level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level       <= RST_LVL;
      pf_distance <= dist_of(RST_LVL);
      pf_degree   <= deg_of(RST_LVL);
    end else begin
      level       <= lvl_nxt;
      pf_distance <= dist_of(lvl_nxt);
      pf_degree   <= deg_of(lvl_nxt);
    end
  end
endmodule

// File: rtl/fdp_throttle.sv
module fdp_throttle
  import fdp_pkg::*;
#(
  parameter int INTERVAL    = 8192,
  parameter int LEVELS      = 5,
  parameter int RESET_LEVEL = 2,
  parameter int BASE_DIST   = 4,
  parameter int DEG_CAP     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_sent,
  input  logic       ev_used,
  input  logic       ev_late,
  input  logic       ev_demand_miss,
  input  logic       ev_poll_miss,
  output logic [2:0] level,
  output logic [6:0] pf_distance,
  output logic [2:0] pf_degree
);
  localparam int CW = $clog2(INTERVAL + 1) + 4;

  logic [NUM_EV-1:0] ev;
  logic [CW-1:0]     cnt     [NUM_EV];
  logic [CW-1:0]     cnt_nxt [NUM_EV];
  logic [CW-1:0]     snap    [NUM_EV];
  logic              close;
  logic              dec_vld;
  step_e             step;

  assign ev[EV_SENT] = ev_sent;
  assign ev[EV_USED] = ev_used;
  assign ev[EV_LATE] = ev_late;
  assign ev[EV_DMND] = ev_demand_miss;
  assign ev[EV_POLL] = ev_poll_miss;

  assign close = ev_sent && (cnt[EV_SENT] == CW'(INTERVAL - 1));

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
    fdp_sat_counter #(.W(CW)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clr     (close),
      .inc     (ev[g]),
      .cnt     (cnt[g]),
      .cnt_nxt (cnt_nxt[g])
    );

    always_ff @(posedge clk) begin
      if (rst)        snap[g] <= '0;
      else if (close) snap[g] <= cnt_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dec_vld <= 1'b0;
    else     dec_vld <= close;
  end

  fdp_classifier #(.W(CW)) u_cls (
    .n_sent (snap[EV_SENT]),
    .n_used (snap[EV_USED]),
    .n_late (snap[EV_LATE]),
    .n_dmnd (snap[EV_DMND]),
    .n_poll (snap[EV_POLL]),
    .step   (step)
  );

  fdp_level_ctrl #(
    .LEVELS      (LEVELS),
    .RESET_LEVEL (RESET_LEVEL),
    .BASE_DIST   (BASE_DIST),
    .DEG_CAP     (DEG_CAP),
    .LW          (3),
    .DW          (7),
    .GW          (3)
  ) u_lvl (
    .clk         (clk),
    .rst         (rst),
    .dec_vld     (dec_vld),
    .step        (step),
    .level       (level),
    .pf_distance (pf_distance),
    .pf_degree   (pf_degree)
  );
endmodule

// File: rtl/fdp_throttle_chk.sv
module fdp_throttle_chk #(
  parameter int LEVELS      = 5,
  parameter int RESET_LEVEL = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       ev_sent,
  input logic       dec_vld,
  input logic [2:0] level,
  input logic [6:0] pf_distance,
  input logic [2:0] pf_degree
);
  // R1
  reset_level_chk: assert property (@(posedge clk)
    rst |=> (level == 3'(RESET_LEVEL)));

  // R9
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    level <= 3'(LEVELS - 1));

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_vld |=> $stable(level));

  // R10
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    dec_vld |=> ((level == $past(level)) || (level == $past(level) + 3'd1)
                 || (level + 3'd1 == $past(level))));

  // R3
  decide_after_sent_chk: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> $past(ev_sent));

  // R2
  dist_deg_move_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(level) |-> ($stable(pf_distance) && $stable(pf_degree)));
endmodule

bind fdp_throttle fdp_throttle_chk #(
  .LEVELS      (LEVELS),
  .RESET_LEVEL (RESET_LEVEL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_sent     (ev_sent),
  .dec_vld     (dec_vld),
  .level       (level),
  .pf_distance (pf_distance),
  .pf_degree   (pf_degree)
);

// File: tb/sim_fdp_throttle.sv
module sim_fdp_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int IVL        = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_sent = 0, ev_used = 0, ev_late = 0, ev_demand_miss = 0, ev_poll_miss = 0;
  logic [2:0] level;
  logic [6:0] pf_distance;
  logic [2:0] pf_degree;

  int total = 0;
  int bad   = 0;
  int model_lvl;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fdp_throttle #(.INTERVAL(IVL)) u0 (
    .clk(clk), .rst(rst), .ev_sent(ev_sent), .ev_used(ev_used), .ev_late(ev_late),
    .ev_demand_miss(ev_demand_miss), .ev_poll_miss(ev_poll_miss),
    .level(level), .pf_distance(pf_distance), .pf_degree(pf_degree)
  );

  function automatic int exp_dist(input int lv);
    return 4 << lv;
  endfunction

  function automatic int exp_deg(input int lv);
    int t[5] = '{1, 1, 2, 4, 4};
    return t[lv];
  endfunction

  // +1 up, -1 down, 0 hold (R4..R8)
  function automatic int exp_step(input int s, input int u, input int l, input int d, input int p);
    bit hi, lo, lt, pl;
    hi = (4 * u >= 3 * s);
    lo = (5 * u < 2 * s);
    lt = (8 * l > u);
    pl = (8 * p > d);
    if (hi) return lt ? 1 : (pl ? -1 : 0);
    if (!lo) return pl ? -1 : (lt ? 1 : 0);
    return (lt || pl) ? -1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " level"}, int'(level), model_lvl);
    check({req, " R2 distance"}, int'(pf_distance), exp_dist(model_lvl));
    check({req, " R2 degree"}, int'(pf_degree), exp_deg(model_lvl));
  endtask

  // One interval: IVL sent pulses, the last in the final cycle.
  task automatic run_ivl(input string req, input int u, input int l, input int d, input int p);
    int n, st;
    n = IVL;
    if (u > n) n = u;
    if (l > n) n = l;
    if (d > n) n = d;
    if (p > n) n = p;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ev_sent        = (k >= n - IVL);
      ev_used        = (k < u);
      ev_late        = (k < l);
      ev_demand_miss = (k < d);
      ev_poll_miss   = (k < p);
      if (k == n / 2) check({req, " R10 mid-interval level"}, int'(level), model_lvl);
    end
    @(negedge clk);
    {ev_sent, ev_used, ev_late, ev_demand_miss, ev_poll_miss} = '0;
    check({req, " R3 not yet updated"}, int'(level), model_lvl);
    @(negedge clk);
    st = exp_step(IVL, u, l, d, p);
    model_lvl = model_lvl + st;
    if (model_lvl > 4) model_lvl = 4;
    if (model_lvl < 0) model_lvl = 0;
    check_outputs(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    model_lvl = 2;
    repeat (3) @(negedge clk);
    check_outputs("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_outputs("R1 after reset");

    // R6 high accuracy cases
    run_ivl("R6 high late", 60, 20, 40, 0);
    run_ivl("R6 high clean", 60, 0, 40, 0);
    run_ivl("R6 high polluting", 60, 0, 40, 20);
    run_ivl("R6 high late+polluting", 60, 20, 40, 20);
    // R7 medium accuracy cases
    run_ivl("R7 med late", 40, 20, 40, 0);
    run_ivl("R7 med clean", 40, 0, 40, 0);
    run_ivl("R7 med late+polluting", 40, 20, 40, 20);
    // R8 low accuracy cases
    run_ivl("R8 low clean", 10, 0, 40, 0);
    run_ivl("R8 low late", 10, 5, 40, 0);
    run_ivl("R8 low polluting", 10, 0, 40, 10);
    // R4 boundaries: 48 is exactly 0.75, 26 medium, 25 low
    run_ivl("R4 exact high edge late", 48, 7, 40, 0);
    run_ivl("R4 edge 26 medium polluting", 26, 0, 40, 6);
    run_ivl("R4 edge 25 low late", 25, 4, 40, 0);
    // R5 boundaries: 6*8 == 48 is not late, 5*8 == 40 is not polluting
    run_ivl("R5 late equal not late", 48, 6, 40, 5);
    run_ivl("R5 polluting edge", 48, 0, 40, 6);
    // R9 saturation at the top
    for (int i = 0; i < 6; i++) run_ivl("R9 saturate up", 60, 30, 40, 0);
    // R9 saturation at the bottom
    for (int i = 0; i < 6; i++) run_ivl("R9 saturate down", 5, 0, 40, 30);
    // R3 clearing: a heavy interval, then one with nothing used
    run_ivl("R3 heavy", 64, 60, 100, 90);
    run_ivl("R3 empty after heavy", 0, 0, 0, 0);
    // random mix checked against the model
    for (int i = 0; i < 30; i++) begin
      int u, l, d, p;
      u = int'($urandom_range(64, 0));
      l = int'($urandom_range(u, 0));
      d = int'($urandom_range(90, 1));
      p = int'($urandom_range(d, 0));
      if ($urandom_range(1, 0) == 0) l = l / 8;
      if ($urandom_range(1, 0) == 0) p = p / 8;
      run_ivl("R6/R7/R8 random", u, l, d, p);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule